// File: doc/BRIEF.md
# Prescaled Compare Timer

A 16-bit free-running counter advances on every tick of a clock prescaler that divides the system clock by 1, 4, 8 or 16. Five compare channels each hold a 16-bit value. When the counter advances onto a channel's value, that channel sets its flag. It also applies a 2-bit action to its own output pin and can raise an interrupt request. When the counter wraps, an overflow flag sets, and that flag has its own interrupt enable.

Software programs the block through a single-cycle write port. It sets the divide ratio, the compare values, the pin actions and the interrupt enables, and it clears flags by writing ones to them. The divide ratio can only be chosen shortly after reset. After that the timebase cannot be disturbed. The counter value is presented on a registered output, so every bit of a read comes from the same edge.

Top module: `cmp_timer`

## Requirements
- R1: `count` is a 16-bit register that resets to 0, never stops, advances by exactly one on each prescaler tick, and wraps from 0xFFFF to 0x0000. All 16 bits update on the same clock edge.
- R2: Write address 0, bits [1:0], selects the divide ratio. 00 gives a tick every cycle, 01 every 4 cycles, 10 every 8 cycles and 11 every 16 cycles. The reset value is 00.
- R3: A write to address 0 is accepted only during the first 64 clock cycles after reset is released. Later writes to address 0 leave the divide ratio unchanged.
- R4: `ovf_flag` sets on the clock edge at which `count` wraps from 0xFFFF to 0x0000. `ovf_irq` is high exactly when `ovf_flag` is set and bit 5 of the enable register (address 2) is 1.
- R5: A write to address 3 clears flags. Bits 0..4 clear the channel flags and bit 5 clears the overflow flag. A bit written as 0 leaves its flag unchanged, and a set in the same cycle as a clear wins.
- R6: Channel i (i = 0..4) compares against the value written at address 4+i. Each channel matches independently when the counter advances onto its value. Its flag sets on the clock edge after `count` shows that value. A channel matches only once per counter value, even if the counter holds that value for several cycles.
- R7: On a match, channel i applies the action code held at address 1, bits [2i+1:2i], to `cmp_pin[i]`. Code 00 leaves the pin unchanged, 01 toggles it, 10 drives it to 0 and 11 drives it to 1. The flag sets whatever the code is, and all pins reset to 0.
- R8: `cmp_irq[i]` is high exactly when `cmp_flag[i]` is set and bit i of the enable register (address 2) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| count | output | 16 | Free-running counter value |
| cmp_flag | output | 5 | Compare match flags |
| ovf_flag | output | 1 | Counter wrap flag |
| cmp_irq | output | 5 | Compare interrupt requests |
| ovf_irq | output | 1 | Wrap interrupt request |
| cmp_pin | output | 5 | Compare output pins |

## Verification
A corrupted prescaler divider becomes visible on `count` within one divide period, as a wrong tick spacing. A wrong lock counter shows up within the first few dozen cycles after reset, as a divide ratio that is accepted late or refused early. A stale match-once state or a wrong compare register shows up one cycle after the counter reaches a programmed value. It appears as a missing flag, a repeated toggle, or a pin that settles to the wrong level. Overflow faults appear only at the wrap, which is up to 65536 ticks after reset, so the wrap path is exercised directly.

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int CW       = 16,
  parameter int NCH      = 5,
  parameter int AW       = 4,
  parameter int LOCK_CYC = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  output logic [CW-1:0]  count,
  output logic [NCH-1:0] cmp_flag,
  output logic           ovf_flag,
  output logic [NCH-1:0] cmp_irq,
  output logic           ovf_irq,
  output logic [NCH-1:0] cmp_pin
);
  localparam int LW    = $clog2(LOCK_CYC + 1);
  localparam int A_PRE = 0;
  localparam int A_ACT = 1;
  localparam int A_EN  = 2;
  localparam int A_CLR = 3;
  localparam int A_CMP = 4;

  logic [1:0]       sel;
  logic [LW-1:0]    lock_cnt;
  logic [3:0]       div, lim;
  logic             fresh;
  logic [2*NCH-1:0] act;
  logic [NCH:0]     en;
  logic [CW-1:0]    cmp_val [NCH];

  wire win_open = lock_cnt < LW'(LOCK_CYC);
  wire wr_clr   = wr_en && wr_addr == AW'(A_CLR);
  wire tick     = div >= lim;
  wire wrap     = tick && count == '1;

  always_comb begin
    unique case (sel)
      2'd0: lim = 4'd0;
      2'd1: lim = 4'd3;
      2'd2: lim = 4'd7;
      default: lim = 4'd15;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_cnt <= '0;
      sel      <= 2'd0;
      act      <= '0;
      en       <= '0;
    end else begin
      if (win_open) lock_cnt <= lock_cnt + 1'b1;
      if (wr_en && wr_addr == AW'(A_PRE) && win_open) sel <= wr_data[1:0];
      if (wr_en && wr_addr == AW'(A_ACT)) act <= wr_data[2*NCH-1:0];
      if (wr_en && wr_addr == AW'(A_EN))  en  <= wr_data[NCH:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div   <= '0;
      count <= '0;
      fresh <= 1'b0;
    end else begin
      div   <= tick ? 4'd0 : div + 1'b1;
      fresh <= tick;
      if (tick) count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ovf_flag <= 1'b0;
    else if (wrap) ovf_flag <= 1'b1;
    else if (wr_clr && wr_data[NCH]) ovf_flag <= 1'b0;
  end

  assign ovf_irq = ovf_flag & en[NCH];
  assign cmp_irq = cmp_flag & en[NCH-1:0];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wire       hit  = fresh && count == cmp_val[i];
    wire [1:0] code = act[2*i +: 2];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp_val[i]  <= '0;
        cmp_flag[i] <= 1'b0;
        cmp_pin[i]  <= 1'b0;
      end else begin
        if (wr_en && wr_addr == AW'(A_CMP + i)) cmp_val[i] <= wr_data;
        if (hit) cmp_flag[i] <= 1'b1;
        else if (wr_clr && wr_data[i]) cmp_flag[i] <= 1'b0;
        if (hit) begin
          unique case (code)
            2'b01: cmp_pin[i] <= ~cmp_pin[i];
            2'b10: cmp_pin[i] <= 1'b0;
            2'b11: cmp_pin[i] <= 1'b1;
            default: cmp_pin[i] <= cmp_pin[i];
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int CW       = 16,
  parameter int NCH      = 5,
  parameter int AW       = 4,
  parameter int LOCK_CYC = 64,
  localparam int LW      = $clog2(LOCK_CYC + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [AW-1:0]  wr_addr,
  input logic [CW-1:0]  wr_data,
  input logic [CW-1:0]  count,
  input logic [NCH-1:0] cmp_flag,
  input logic           ovf_flag,
  input logic           ovf_irq,
  input logic [NCH-1:0] cmp_pin,
  input logic [1:0]     sel,
  input logic [LW-1:0]  lock_cnt,
  input logic [CW-1:0]  cmp_val [NCH]
);
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count != $past(count) |-> count == CW'($past(count) + 1'b1));

  assert_sel_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_cnt) >= LW'(LOCK_CYC) |-> $stable(sel));

  assert_ovf_on_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> count == '0 && $past(count) == '1);

  assert_ovf_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> ovf_flag);

  assert_ovf_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_flag) |-> $past(wr_en && wr_addr == AW'(3) && wr_data[NCH]));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    assert_flag_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmp_flag[i]) |-> $past(count) == $past(cmp_val[i]));

    assert_pin_with_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cmp_pin[i]) |-> cmp_flag[i]);
  end
endmodule

bind cmp_timer cmp_timer_chk #(.CW(CW), .NCH(NCH), .AW(AW), .LOCK_CYC(LOCK_CYC)) u_chk (.*);

// File: tb/sim_cmp_timer.sv
module sim_cmp_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic [4:0]  cmp_flag, cmp_irq, cmp_pin;
  logic        ovf_flag, ovf_irq;
  int checks = 0;
  int fails = 0;

  cmp_timer u0 (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_val(input logic [15:0] v, input int lim, input string req);
    int n = 0;
    while (count != v && n < lim) begin
      @(negedge clk);
      n++;
    end
    chk(count == v, req, "counter reaches target", count, v);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(count == 0, "R1", "count in reset", count, 0);
    chk(cmp_flag == 0 && !ovf_flag, "R5", "flags in reset", {ovf_flag, cmp_flag}, 0);
    chk(cmp_pin == 0, "R7", "pins in reset", cmp_pin, 0);
    chk(cmp_irq == 0 && !ovf_irq, "R8", "irqs in reset", {ovf_irq, cmp_irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    begin
      logic [15:0] c0 = count;
      repeat (10) @(negedge clk);
      chk(count - c0 == 10, "R1", "advance at divide 1", count - c0, 10);
    end
  endtask

  task automatic t_div(input int code, input int per);
    logic [15:0] c0;
    do_reset();
    wr(0, code);
    @(negedge clk);
    c0 = count;
    repeat (4 * per) @(negedge clk);
    chk(count - c0 == 4, "R2", $sformatf("ticks for code %0d", code), count - c0, 4);
  endtask

  task automatic t_lock();
    logic [15:0] c0;
    do_reset();
    repeat (58) @(negedge clk);
    wr(0, 1);
    @(negedge clk);
    c0 = count;
    repeat (16) @(negedge clk);
    chk(count - c0 == 4, "R3", "write inside window accepted", count - c0, 4);
    do_reset();
    repeat (70) @(negedge clk);
    wr(0, 3);
    @(negedge clk);
    c0 = count;
    repeat (16) @(negedge clk);
    chk(count - c0 == 16, "R3", "late write ignored", count - c0, 16);
  endtask

  task automatic t_toggle();
    logic [15:0] tgt;
    do_reset();
    wr(1, 1);
    wr(2, 1);
    tgt = count + 20;
    wr(4, tgt);
    wait_val(tgt, 40, "R6");
    chk(cmp_flag[0] == 0, "R6", "flag not yet set at match value", cmp_flag[0], 0);
    @(negedge clk);
    chk(cmp_flag[0] == 1, "R6", "flag one cycle after match", cmp_flag[0], 1);
    chk(cmp_pin[0] == 1, "R7", "toggle to 1", cmp_pin[0], 1);
    chk(cmp_irq[0] == 1, "R8", "irq enabled", cmp_irq[0], 1);
    wr(3, 1);
    chk(cmp_flag[0] == 0 && cmp_irq[0] == 0, "R5", "write-one clear", cmp_flag[0], 0);
    tgt = count + 10;
    wr(4, tgt);
    wait_val(tgt, 30, "R6");
    @(negedge clk);
    chk(cmp_pin[0] == 0, "R7", "toggle back to 0", cmp_pin[0], 0);
  endtask

  task automatic t_drive();
    logic [15:0] c;
    do_reset();
    wr(1, (3 << 2) | (1 << 4));
    c = count;
    wr(5, c + 15);
    wr(6, c + 25);
    wr(7, c + 30);
    wait_val(16'(c + 15), 40, "R6");
    @(negedge clk);
    chk(cmp_flag[1] == 1 && cmp_flag[2] == 0, "R6", "channels match independently", cmp_flag[2:1], 1);
    chk(cmp_pin[1] == 1, "R7", "drive high", cmp_pin[1], 1);
    chk(cmp_irq[1] == 0, "R8", "irq masked while flag set", cmp_irq[1], 0);
    wait_val(16'(c + 30), 40, "R6");
    @(negedge clk);
    chk(cmp_pin[2] == 1, "R7", "toggle ch2 high", cmp_pin[2], 1);
    chk(cmp_flag[3] == 1 && cmp_pin[3] == 0, "R7", "code 00 sets flag, pin kept", {cmp_flag[3], cmp_pin[3]}, 2);
    wr(3, 0);
    chk(cmp_flag[3:1] == 3'b111, "R5", "zero write keeps flags", cmp_flag[3:1], 7);
    wr(3, 1 << 2);
    chk(cmp_flag[3:1] == 3'b101, "R5", "only written bit clears", cmp_flag[3:1], 5);
    wr(1, (3 << 2) | (2 << 4));
    c = count + 12;
    wr(6, c);
    wait_val(c, 30, "R6");
    @(negedge clk);
    chk(cmp_pin[2] == 0, "R7", "drive low", cmp_pin[2], 0);
    chk(cmp_pin[1] == 1, "R7", "other pin held", cmp_pin[1], 1);
  endtask

  task automatic t_once();
    logic [15:0] tgt;
    do_reset();
    wr(0, 3);
    wr(1, 1 << 8);
    tgt = count + 3;
    wr(8, tgt);
    wait_val(tgt, 80, "R6");
    @(negedge clk);
    chk(cmp_flag[4] == 1 && cmp_pin[4] == 1, "R6", "slow-tick match", {cmp_flag[4], cmp_pin[4]}, 3);
    wr(3, 1 << 4);
    repeat (6) @(negedge clk);
    chk(count == tgt, "R6", "counter still on value", count, tgt);
    chk(cmp_flag[4] == 0, "R6", "no rematch on held value", cmp_flag[4], 0);
    chk(cmp_pin[4] == 1, "R7", "single toggle per value", cmp_pin[4], 1);
  endtask

  task automatic t_ovf();
    do_reset();
    wr(2, 1 << 5);
    wait_val(16'hFFFF, 70000, "R4");
    chk(ovf_flag == 0, "R4", "no flag before wrap", ovf_flag, 0);
    @(negedge clk);
    chk(ovf_flag == 1 && count == 0, "R4", "flag at wrap", {ovf_flag, count}, 32'h10000);
    chk(ovf_irq == 1, "R4", "overflow irq", ovf_irq, 1);
    wr(3, 5'h1f);
    chk(ovf_flag == 1, "R5", "channel bits leave overflow flag", ovf_flag, 1);
    wr(3, 1 << 5);
    chk(ovf_flag == 0 && ovf_irq == 0, "R5", "overflow cleared", ovf_flag, 0);
  endtask

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_div(1, 4);
    t_div(2, 8);
    t_div(3, 16);
    t_lock();
    t_toggle();
    t_drive();
    t_once();
    t_ovf();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule